// File: doc/BRIEF.md
# UART Transmit Serializer

This block is the sending half of an asynchronous serial port. Software writes a character into a holding register. Once the serial line is free, the character moves into a separate shift register and goes out as one frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop field of one, one and a half or two bit times. The line stays high between frames.

The clock for the frame comes from an external pulse at sixteen times the baud rate, and one bit lasts sixteen of these ticks. A new frame starts only on a tick, so after a write the start bit is delayed by no more than one tick period. If another character is waiting when a stop field ends, the next frame begins on that same tick, with no idle gap between frames. The block has two status outputs. One reports that the holding register is free. The other reports that nothing is left to send, and it can switch an RS485 line driver off. A break control forces the line low for as long as it is set. While break is set, the frame timing continues unchanged.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A write (`wr_en` high for one clock) clears `hold_empty` and `tx_empty` at the next clock edge. The start bit begins at the first clock edge after the write where `baud_tick` is high, and `hold_empty` returns to 1 at that same edge.
- R3: Every start, data and parity bit lasts exactly 16 `baud_tick` pulses. The start bit is 0 and the data bits follow it least significant bit first.
- R4: `len_sel` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `wr_data` at or above that length are never sent.
- R5: When `par_en` is 1, a parity bit follows the data. With `par_even` = 1 the parity bit makes the total count of ones in data plus parity even, and with `par_even` = 0 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R6: The stop field is 1 and lasts 16 ticks when `stop_sel` is 0. When `stop_sel` is 1 it lasts 24 ticks for 5-bit characters and 32 ticks for all other lengths.
- R7: While `brk_force` is 1, `txd` is 0 whatever the frame state, and the frame timing (including when `tx_empty` rises) is unchanged. When `brk_force` clears, `txd` again shows the frame state.
- R8: If a character is waiting when a stop field ends, its start bit begins on that same tick and `tx_empty` stays 0. Otherwise `tx_empty` rises at the clock edge that ends the stop field.
- R9: A second write before the held character has moved into the shift register replaces the held character. Only the later value is sent.
- R10: `txd` is 1 whenever no frame is in progress and break is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse at 16x the baud rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| len_sel | input | 2 | Character length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel | input | 1 | 0 = one stop bit, 1 = long stop field |
| brk_force | input | 1 | Hold the serial line low |
| txd | output | 1 | Serial data output |
| hold_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding and shift registers are both empty and the last stop bit has finished |

## Verification
The bench builds the block with its defaults: an 8-bit character limit and 16 ticks per bit. The bench itself generates `baud_tick` every four clocks. With these values all four character lengths can be tested, and each frame lasts only a few hundred clocks. Because the bench counts clocks exactly, it can check the stop-field lengths (16, 24 and 32 ticks) and the one-tick start delay to the clock cycle. It can also check that back-to-back frames leave no gap and that a frame sent under break takes exactly as long as a normal one.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_phase_e;
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              full_q, full_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (take)  full_d = 1'b0;
    if (wr_en) begin
      data_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= data_d;
    end
  end

  assign hold_data = data_q;
  assign hold_full = full_q;

  // the sequencer only moves a character that is really waiting
  assert_take_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             bit_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign bit_end = run && tick && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (bit_end) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // bit time only advances on baud ticks
  assert_count_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 5,
  parameter int LEN_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bit_end,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              stop_sel,
  output logic              take,
  output logic              run,
  output logic [CNT_W-1:0]  limit,
  output logic              line
);
  localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT/2 - 1);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2*TICKS_PER_BIT - 1);
  localparam logic [LEN_W:0]   CHAR_MIN = (LEN_W+1)'(DATA_W - 3);

  tx_phase_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic              par_q, par_d;
  logic              line_q, line_d;

  logic [LEN_W:0]    char_len;
  logic [LEN_W-1:0]  last_idx;
  logic [DATA_W-1:0] masked;
  logic              par_calc;
  logic              load;

  assign char_len = CHAR_MIN + (LEN_W+1)'(len_sel);
  assign last_idx = LEN_W'(char_len - 1'b1);

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      masked[i] = hold_data[i] & (i < int'(char_len));
  end
  assign par_calc = (^masked) ^ ~par_even;

  always_comb begin
    limit = LIM_ONE;
    if (state_q == TX_STOP && stop_sel)
      limit = (len_sel == 2'd0) ? LIM_HALF : LIM_TWO;
  end

  assign run  = (state_q != TX_IDLE);
  assign load = hold_full && (((state_q == TX_IDLE) && tick) ||
                              ((state_q == TX_STOP) && bit_end));
  assign take = load;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    par_d   = par_q;
    line_d  = line_q;
    unique case (state_q)
      TX_IDLE: line_d = 1'b1;
      TX_START: if (bit_end) begin
        state_d = TX_DATA;
        line_d  = sh_q[0];
        sh_d    = sh_q >> 1;
        idx_d   = '0;
      end
      TX_DATA: if (bit_end) begin
        if (idx_q == last_idx) begin
          state_d = par_en ? TX_PAR : TX_STOP;
          line_d  = par_en ? par_q : 1'b1;
        end else begin
          idx_d  = idx_q + 1'b1;
          line_d = sh_q[0];
          sh_d   = sh_q >> 1;
        end
      end
      TX_PAR: if (bit_end) begin
        state_d = TX_STOP;
        line_d  = 1'b1;
      end
      TX_STOP: if (bit_end) begin
        state_d = TX_IDLE;
        line_d  = 1'b1;
      end
      default: begin
        state_d = TX_IDLE;
        line_d  = 1'b1;
      end
    endcase
    if (load) begin
      state_d = TX_START;
      sh_d    = masked;
      par_d   = par_calc;
      line_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      par_q   <= par_d;
      line_q  <= line_d;
    end
  end

  assign line = line_q;

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_START) |-> !line_q);
  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> line_q);
  assert_index_in_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_DATA) |-> ({1'b0, idx_q} < char_len));
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              stop_sel,
  input  logic              brk_force,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  localparam int CNT_W = $clog2(2*TICKS_PER_BIT);
  localparam int LEN_W = $clog2(DATA_W);

  logic              rst_q;
  logic              take, run, bit_end, line, hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [CNT_W-1:0]  limit;

  tx_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_q)
  );

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .hold_data(hold_data), .hold_full(hold_full)
  );

  tx_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_q), .tick(baud_tick), .run(run),
    .limit(limit), .bit_end(bit_end)
  );

  tx_frame_seq #(
    .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT),
    .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_q), .tick(baud_tick), .bit_end(bit_end),
    .hold_full(hold_full), .hold_data(hold_data), .len_sel(len_sel),
    .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
    .take(take), .run(run), .limit(limit), .line(line)
  );

  assign txd        = brk_force ? 1'b0 : line;
  assign hold_empty = !hold_full;
  assign tx_empty   = !run && !hold_full;

  // character leaves the holding register only on a baud tick
  assert_load_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(hold_empty) |-> $past(baud_tick));
  // transmitter goes empty only at the tick that closes a stop field
  assert_empty_at_tick_R8: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(tx_empty) |-> $past(baud_tick));
endmodule

// File: tb/uart_tx_serializer_bench.sv
module uart_tx_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int TPB        = 16;
  localparam int BITC       = TPB * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [1:0] len_sel;
  logic       par_en, par_even, stop_sel, brk_force;
  logic       txd, hold_empty, tx_empty;

  int checks = 0;
  int errors = 0;
  int tdiv;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv      <= 0;
      baud_tick <= 1'b0;
    end else begin
      tdiv      <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == TICK_DIV-1);
    end
  end

  uart_tx_serializer u_uart_tx_serializer (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .len_sel(len_sel), .par_en(par_en),
    .par_even(par_even), .stop_sel(stop_sel), .brk_force(brk_force),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  // called at a negedge; returns one negedge later
  task automatic write_byte(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic config_line(input logic [1:0] ls, input logic pe, input logic pev,
                             input logic ss);
    len_sel = ls; par_en = pe; par_even = pev; stop_sel = ss;
  endtask

  // decodes one frame from its falling edge and checks its exact length
  task automatic check_frame(input logic [7:0] d, input int n, input bit pe,
                             input bit pev, input int stop_ticks, input bit chained,
                             input string tag);
    int w = 0;
    int pos;
    int nb    = 1 + n + (pe ? 1 : 0);
    int total = (nb * TPB + stop_ticks) * TICK_DIV;
    logic [7:0] mask = 8'((16'd1 << n) - 1);
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    chk({tag, " R2 start seen"}, 32'(w < 4000), 32'd1);
    repeat (BITC/2) @(negedge clk);
    pos = BITC/2;
    chk({tag, " R3 start bit"}, 32'(txd), 32'd0);
    for (int i = 0; i < n; i++) begin
      repeat (BITC) @(negedge clk);
      pos += BITC;
      chk($sformatf("%s R3/R4 data bit %0d", tag, i), 32'(txd), 32'(d[i]));
    end
    if (pe) begin
      repeat (BITC) @(negedge clk);
      pos += BITC;
      chk({tag, " R5 parity"}, 32'(txd), 32'((^(d & mask)) ^ !pev));
    end
    repeat (BITC) @(negedge clk);
    pos += BITC;
    chk({tag, " R4/R6 stop level"}, 32'(txd), 32'd1);
    repeat (total - 1 - pos) @(negedge clk);
    chk({tag, " R6 stop still running"}, {30'd0, txd, tx_empty}, 32'b10);
    @(negedge clk);
    if (chained)
      chk({tag, " R8 next start without gap"}, {30'd0, txd, tx_empty}, 32'b00);
    else
      chk({tag, " R6/R8/R10 end of frame idle"}, {30'd0, txd, tx_empty}, 32'b11);
  endtask

  task automatic t_reset();
    chk("R1 reset txd", 32'(txd), 32'd1);
    chk("R1 reset hold_empty", 32'(hold_empty), 32'd1);
    chk("R1 reset tx_empty", 32'(tx_empty), 32'd1);
  endtask

  task automatic t_start_align();
    config_line(2'd3, 1'b0, 1'b0, 1'b0);
    write_byte(8'hA5);
    chk("R2 hold_empty after write", 32'(hold_empty), 32'd0);
    chk("R2 tx_empty after write", 32'(tx_empty), 32'd0);
    while (!baud_tick) @(negedge clk);
    chk("R2 line high before tick", {30'd0, txd, hold_empty}, 32'b10);
    @(negedge clk);
    chk("R2 start at tick edge", {30'd0, txd, hold_empty}, 32'b01);
    check_frame(8'hA5, 8, 1'b0, 1'b0, TPB, 1'b0, "8N1");
  endtask

  task automatic t_lengths();
    config_line(2'd0, 1'b0, 1'b0, 1'b0);
    write_byte(8'hDF);
    check_frame(8'hDF, 5, 1'b0, 1'b0, TPB, 1'b0, "len5");
    config_line(2'd1, 1'b0, 1'b0, 1'b0);
    write_byte(8'hBF);
    check_frame(8'hBF, 6, 1'b0, 1'b0, TPB, 1'b0, "len6");
    config_line(2'd2, 1'b0, 1'b0, 1'b0);
    write_byte(8'h7F);
    check_frame(8'h7F, 7, 1'b0, 1'b0, TPB, 1'b0, "len7");
  endtask

  task automatic t_parity();
    config_line(2'd2, 1'b1, 1'b0, 1'b0);
    write_byte(8'h93);
    check_frame(8'h93, 7, 1'b1, 1'b0, TPB, 1'b0, "7O1");
    config_line(2'd2, 1'b1, 1'b1, 1'b0);
    write_byte(8'h93);
    check_frame(8'h93, 7, 1'b1, 1'b1, TPB, 1'b0, "7E1");
    config_line(2'd3, 1'b1, 1'b1, 1'b0);
    write_byte(8'hA5);
    check_frame(8'hA5, 8, 1'b1, 1'b1, TPB, 1'b0, "8E1");
  endtask

  task automatic t_stops();
    config_line(2'd0, 1'b0, 1'b0, 1'b1);
    write_byte(8'h0A);
    check_frame(8'h0A, 5, 1'b0, 1'b0, TPB + TPB/2, 1'b0, "5N1.5");
    config_line(2'd3, 1'b1, 1'b0, 1'b1);
    write_byte(8'h3C);
    check_frame(8'h3C, 8, 1'b1, 1'b0, 2*TPB, 1'b0, "8O2");
  endtask

  task automatic t_break();
    int total = (10 * TPB) * TICK_DIV;
    int lows  = 0;
    config_line(2'd3, 1'b0, 1'b0, 1'b0);
    brk_force = 1'b1;
    @(negedge clk);
    chk("R7 break low while idle", 32'(txd), 32'd0);
    write_byte(8'h55);
    while (!hold_empty) @(negedge clk);
    for (int k = 1; k < total; k++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk("R7 line low through whole frame", 32'(lows), 32'(total - 1));
    chk("R7 frame timing kept", 32'(tx_empty), 32'd0);
    @(negedge clk);
    chk("R7 tx_empty at normal end", 32'(tx_empty), 32'd1);
    brk_force = 1'b0;
    @(negedge clk);
    chk("R7/R10 line restored", 32'(txd), 32'd1);
  endtask

  task automatic t_back_to_back();
    config_line(2'd3, 1'b0, 1'b0, 1'b0);
    write_byte(8'hC3);
    fork
      check_frame(8'hC3, 8, 1'b0, 1'b0, TPB, 1'b1, "first");
      begin
        while (!hold_empty) @(negedge clk);
        write_byte(8'h5A);
      end
    join
    check_frame(8'h5A, 8, 1'b0, 1'b0, TPB, 1'b0, "second");
  endtask

  task automatic t_overwrite();
    config_line(2'd3, 1'b0, 1'b0, 1'b0);
    while (!baud_tick) @(negedge clk);
    write_byte(8'h11);
    write_byte(8'h3C);
    chk("R9 still holding before tick", 32'(hold_empty), 32'd0);
    check_frame(8'h3C, 8, 1'b0, 1'b0, TPB, 1'b0, "R9 overwrite");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; brk_force = 1'b0;
    config_line(2'd3, 1'b0, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_align();
    t_lengths();
    t_parity();
    t_stops();
    t_break();
    t_back_to_back();
    t_overwrite();
    repeat (8) @(negedge clk);
    chk("R10 idle high at end", 32'(txd), 32'd1);
    summary();
    $finish;
  end
endmodule